// File: doc/BRIEF.md
# RFID Tag Serial Code Readout Sequencer

This block sits in a passive identification tag and plays a fixed identification code out of a small read-only array, one bit per bit period. It is timed by the field clock recovered from the reader's carrier. The code is supplied as a 128-bit parameter and organised as 8 rows of 16 bits. A bit index is split into a row address and a column address, and the column address picks one bit of the selected row.

Two selections set the transmission: the code length (128, 96, 64 or 32 bits) and the field-clock divisor that fixes the bit period. The divisor can be a power of two or one of the ratios 40, 50, 80 and 100. Both selections are captured while reset is held and stay frozen afterwards. Transmission starts by itself as soon as reset is released and repeats the code without any gap. A downstream modulator receives the serial data bit, a bit-period clock, a one-cycle strobe at each bit boundary and a one-cycle strobe at the middle of each bit.

Top module: `rfid_readout_seq`

## Requirements
- R1: `len_sel` and `rate_sel` are captured on every clock edge while `rst_n` is low. Changes to them while `rst_n` is high have no effect on any output.
- R2: `rate_sel` codes 0..9 select field-clock divisors 8, 16, 32, 40, 50, 64, 80, 100, 128 and 256. `bound_stb` is high for exactly one cycle every divisor cycles.
- R3: `mid_stb` is high for one cycle, exactly divisor/2 cycles after each `bound_stb`, and never in the same cycle as `bound_stb`.
- R4: `bit_clk` is high for the first divisor/2 cycles of each bit period and low for the rest. It rises together with `bound_stb`.
- R5: `len_sel` codes 0,1,2,3 select lengths of 128, 96, 64 and 32 bits. After the last bit, the index returns to bit 0 at the very next boundary, with no gap.
- R6: Bit index i is sent from row i/16, column i%16, with the most significant column first. In effect, `data` carries `CODE[i ^ 15]`, so `CODE[15]` is sent first.
- R7: While `rst_n` is low, all outputs are 0. On the first clock edge after release, bit 0 starts: `bound_stb` and `bit_clk` go high and `data` shows bit 0. No command is required.
- R8: `data` changes only in a cycle where `bound_stb` is high.
- R9: `rate_sel` codes 10..15 select divisor 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Field clock recovered from the carrier |
| rst_n | input | 1 | Synchronous active-low reset; the selections are captured while it is low |
| len_sel | input | 2 | Code length select (0:128, 1:96, 2:64, 3:32) |
| rate_sel | input | 4 | Divisor select (0..9 as in R2; 10..15 give 8) |
| data | output | 1 | Serial code bit for the current bit period |
| bit_clk | output | 1 | Bit-period clock, high in the first half of each period |
| bound_stb | output | 1 | One-cycle strobe at the first cycle of every bit |
| mid_stb | output | 1 | One-cycle strobe at the middle of every bit |

## Verification
Two things coincide at the end of the code: a bit boundary and the wrap of the bit index back to zero. Both must land in one cycle, so that bit 0 appears right at the boundary that follows the last bit. The bench provokes this with the shortest code at the shortest divisor, and also with every other length. It runs each stream past at least one wrap and compares every cycle against a model that computes the index as a cycle count divided by the divisor, modulo the length. The odd half-divisor case (50) is covered by the same per-cycle comparison of the mid strobe and the bit clock.

// File: rtl/rfid_seq_pkg.sv
package rfid_seq_pkg;

    localparam int DIV_W = 9;

    typedef struct packed {
        logic [1:0] len_code;
        logic [3:0] rate_code;
    } seq_cfg_t;

    function automatic logic [DIV_W-1:0] div_of(input logic [3:0] code);
        logic [DIV_W-1:0] d;
        case (code)
            4'd0:    d = 9'd8;
            4'd1:    d = 9'd16;
            4'd2:    d = 9'd32;
            4'd3:    d = 9'd40;
            4'd4:    d = 9'd50;
            4'd5:    d = 9'd64;
            4'd6:    d = 9'd80;
            4'd7:    d = 9'd100;
            4'd8:    d = 9'd128;
            4'd9:    d = 9'd256;
            default: d = 9'd8;
        endcase
        return d;
    endfunction

    function automatic logic [7:0] len_of(input logic [1:0] code);
        logic [7:0] n;
        case (code)
            2'd0:    n = 8'd128;
            2'd1:    n = 8'd96;
            2'd2:    n = 8'd64;
            default: n = 8'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bound,
    output logic             mid,
    output logic             half_hi,
    output logic             step
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] ph;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [DIV_W-1:0] half;

    always_comb begin
        half = div >> 1;
        s_d  = s_q;
        if (!run) begin
            s_d.ph = '0;
        end else if (s_q.ph == div - ONE) begin
            s_d.ph = '0;
        end else begin
            s_d.ph = s_q.ph + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bound   = run && (s_q.ph == '0);
    assign mid     = run && (s_q.ph == half);
    assign half_hi = run && (s_q.ph < half);
    assign step    = run && (s_q.ph == div - ONE);

    // R2: a boundary is never followed directly by another boundary (divisor >= 8)
    p_bound_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bound |=> !bound);

    // R2: the last cycle of a period is followed by a boundary
    p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && run) |=> bound);

    // R3: mid strobe and boundary strobe are exclusive
    p_mid_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bound, mid}));

endmodule

// File: rtl/bit_addr_counter.sv
module bit_addr_counter #(
    parameter int ROWS = 8,
    parameter int COLS = 16,
    localparam int IDX_W = $clog2(ROWS * COLS),
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IDX_W-1:0] last_idx,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } addr_state_t;

    addr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (s_q.idx == last_idx) s_d.idx = '0;
            else                     s_d.idx = s_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign col = s_q.idx[COL_W-1:0];
    assign row = s_q.idx[IDX_W-1:COL_W];

    // R5: after the last index is stepped past, the index is 0
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && s_q.idx == last_idx) |=> (s_q.idx == '0));

    // R5: the index never leaves the selected length
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.idx <= last_idx);

endmodule

// File: rtl/code_rom.sv
module code_rom #(
    parameter int ROWS = 8,
    parameter int COLS = 16,
    parameter logic [ROWS*COLS-1:0] CODE = '0,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic             bit_out
);
    logic [COLS-1:0] row_bits [ROWS];
    logic [COLS-1:0] sel_row;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_bits[r] = CODE[r*COLS +: COLS];
    end

    always_comb begin
        sel_row = row_bits[row];
        // most significant column leaves first
        bit_out = sel_row[COL_W'(COLS - 1) - col];
    end

endmodule

// File: rtl/rfid_readout_seq.sv
module rfid_readout_seq #(
    parameter int ROWS = 8,
    parameter int COLS = 16,
    parameter logic [ROWS*COLS-1:0] CODE = 128'hC3A5_0F1E_9B27_64D8_5A3C_E1F0_8D42_B719
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] len_sel,
    input  logic [3:0] rate_sel,
    output logic       data,
    output logic       bit_clk,
    output logic       bound_stb,
    output logic       mid_stb
);
    import rfid_seq_pkg::*;

    localparam int IDX_W = $clog2(ROWS * COLS);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);

    typedef struct packed {
        seq_cfg_t cfg;
        logic     run;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [DIV_W-1:0] div;
    logic [IDX_W-1:0] last_idx;
    logic [7:0]       len_n;
    logic             step, bound, mid, half_hi, rom_bit;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;

    always_comb begin
        s_d     = s_q;
        s_d.run = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cfg.len_code  <= len_sel;
            s_q.cfg.rate_code <= rate_sel;
            s_q.run           <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        div      = div_of(s_q.cfg.rate_code);
        len_n    = len_of(s_q.cfg.len_code);
        last_idx = IDX_W'(len_n - 8'd1);
    end

    rate_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(s_q.run), .div(div),
        .bound(bound), .mid(mid), .half_hi(half_hi), .step(step)
    );

    bit_addr_counter #(.ROWS(ROWS), .COLS(COLS)) u_addr (
        .clk(clk), .rst_n(rst_n), .step(step), .last_idx(last_idx),
        .row(row), .col(col)
    );

    code_rom #(.ROWS(ROWS), .COLS(COLS), .CODE(CODE)) u_rom (
        .row(row), .col(col), .bit_out(rom_bit)
    );

    assign data      = s_q.run & rom_bit;
    assign bit_clk   = half_hi;
    assign bound_stb = bound;
    assign mid_stb   = mid;

    // R1: configuration is frozen while out of reset
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(s_q.cfg));

    // R8: data only moves on a boundary
    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && $past(s_q.run) && !bound_stb) |-> $stable(data));

    // R4: the bit clock rises only on a boundary
    p_bitclk_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_clk) |-> bound_stb);

endmodule

// File: tb/tb_rfid_readout_seq.sv
module tb_rfid_readout_seq;
    localparam logic [127:0] CODE = 128'h1F2E_3D4C_5B6A_7988_A7B6_C5D4_E3F2_0119;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] len_sel = 2'd0;
    logic [3:0] rate_sel = 4'd0;
    logic       data, bit_clk, bound_stb, mid_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rfid_readout_seq #(.CODE(CODE)) dut (
        .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .rate_sel(rate_sel),
        .data(data), .bit_clk(bit_clk), .bound_stb(bound_stb), .mid_stb(mid_stb)
    );

    function automatic int div_m(input int code);
        case (code)
            0: return 8;    1: return 16;  2: return 32;  3: return 40;
            4: return 50;   5: return 64;  6: return 80;  7: return 100;
            8: return 128;  9: return 256;
            default: return 8;
        endcase
    endfunction

    function automatic int len_m(input int code);
        case (code)
            0: return 128; 1: return 96; 2: return 64; default: return 32;
        endcase
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // hold reset with the given selections, check quiet outputs, release (R7)
    task automatic do_reset(input int lc, input int rc);
        @(negedge clk);
        rst_n = 1'b0; len_sel = 2'(lc); rate_sel = 4'(rc);
        repeat (3) @(negedge clk);
        chk("R7 data in reset", data, 1'b0);
        chk("R7 bit_clk in reset", bit_clk, 1'b0);
        chk("R7 bound_stb in reset", bound_stb, 1'b0);
        chk("R7 mid_stb in reset", mid_stb, 1'b0);
        rst_n = 1'b1;
    endtask

    // compare ncyc cycles; optionally scramble inputs after 'scr' cycles (R1)
    task automatic run_stream(input string tag, input int lc, input int rc,
                              input int ncyc, input int scr);
        int dv, ln, ph, idx, stable_errs;
        dv = div_m(rc); ln = len_m(lc);
        do_reset(lc, rc);
        stable_errs = errors;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            ph  = c % dv;
            idx = (c / dv) % ln;
            chk({tag, " R2 bound_stb"}, bound_stb, ph == 0);
            chk({tag, " R3 mid_stb"}, mid_stb, ph == dv / 2);
            chk({tag, " R4 bit_clk"}, bit_clk, ph < dv / 2);
            chk({tag, " R6 data"}, data, CODE[idx ^ 15]);
            if (scr > 0 && c == scr) begin
                len_sel = 2'(~lc); rate_sel = 4'd9;
            end
        end
        if (errors == stable_errs)
            $display("ok  %s", tag);
    endtask

    task automatic t_first_bit_r7;
        do_reset(3, 0);
        @(negedge clk);
        chk("R7 first bound", bound_stb, 1'b1);
        chk("R7 first bit_clk", bit_clk, 1'b1);
        chk("R7 first data", data, CODE[15]);
    endtask

    task automatic t_wrap_short_r5;  run_stream("R5 wrap len32 div8", 3, 0, 32*8*2 + 20, 0); endtask
    task automatic t_full128_r6;     run_stream("R6 len128 div8", 0, 0, 128*8 + 40, 0); endtask
    task automatic t_len96_r5;       run_stream("R5 len96 div40", 1, 3, 96*40 + 100, 0); endtask
    task automatic t_len64_odd_r3;   run_stream("R3 len64 div50", 2, 4, 64*50 + 120, 0); endtask
    task automatic t_cfg_freeze_r1;  run_stream("R1 cfg frozen", 3, 0, 32*8 + 300, 40); endtask

    task automatic t_all_rates_r9;
        for (int rc = 0; rc < 16; rc++)
            run_stream($sformatf("R9 rate code %0d", rc), 3, rc, div_m(rc) * 4 + 3, 0);
    endtask

    task automatic t_restart_r7;
        run_stream("R7 restart A", 2, 1, 300, 0);
        run_stream("R7 restart B", 3, 0, 200, 0);
    endtask

    task automatic t_data_hold_r8;
        run_stream("R8 data hold div256", 0, 9, 256*3, 0);
    endtask

    initial begin
        t_first_bit_r7();
        t_wrap_short_r5();
        t_full128_r6();
        t_len96_r5();
        t_len64_odd_r3();
        t_cfg_freeze_r1();
        t_all_rates_r9();
        t_restart_r7();
        t_data_hold_r8();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule